// File: doc/BRIEF.md
# Sequential Sine/Cosine Rotator

This block computes the cosine and sine of a phase angle with a single shared shift-and-add datapath. The datapath performs one micro-rotation per clock, so a result takes a few cycles rather than a deep pipeline. The caller presents a 16-bit phase word and an iteration count, then pulses a start strobe. In the phase word the whole unsigned range spans one full turn, so one code is 360/65536 degrees. The block raises busy while it works and pulses done when the two signed results are valid.

The phase is first folded into the half-plane between -90 and +90 degrees. The folded angle is driven toward zero by a fixed sequence of arctangent steps. The x register starts from a gain constant chosen for the requested number of steps, so no multiply follows the loop. If the phase was folded, both components are negated at the end. The final values are clipped into the 17-bit output range.

Top module: `cordic_rot_engine`

## Requirements
- R1: With 16 iterations, cos_o and sin_o equal 65536·cos(θ) and 65536·sin(θ) to within 50 LSB, where θ = 2π·phase_i/65536 and phase_i is read as a two's-complement value.
- R2: A phase whose two top bits are 01 or 10 lies outside -90..+90 degrees. Such a phase is shifted by half a turn (0x8000) before the iterations, and both results are negated afterwards.
- R3: An iteration count of 0 is treated as 1, and any count above 16 is treated as 16.
- R4: The x start value is a Q16 gain that depends on the count. With one iteration at phase 0, both outputs equal 46341 ± 2, which is 0.70711 in Q16.
- R5: done_o is high in the cycle after the (n+2)-th rising edge, counting the edge that samples start_i, where n is the clamped count.
- R6: busy_o rises on the edge that accepts start_i and stays high until the edge that raises done_o. busy_o is low while done_o is high.
- R7: done_o stays high for exactly one cycle per accepted start.
- R8: A start_i that arrives while busy_o is high is ignored. It produces no extra done pulse and does not change the result in flight.
- R9: cos_o and sin_o change only in a cycle in which done_o is high. At all other times they hold their last values.
- R10: Results are clipped to -65536..65535. A full-scale output, such as cos at phase 0, never wraps to a negative value.
- R11: A start_i presented in the cycle in which done_o is high is accepted and begins a new computation.
- R12: After reset, busy_o and done_o are 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a computation when idle |
| phase_i | input | 16 | Angle, full range = one turn |
| iter_i | input | 5 | Requested micro-rotation count (clamped 1..16) |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| cos_o | output | 17 | Signed Q16 cosine |
| sin_o | output | 17 | Signed Q16 sine |

## Verification
Two events can fall in the same cycle: a result completing with its done pulse, and a new start request. The bench raises start_i in the very cycle in which done_o is seen high. The scoreboard then expects a second, independent result exactly n+2 edges after that cycle, and the first result must still compare correctly. The bench also raises start_i in the middle of a run to provoke the opposite case, a start that collides with busy. Any done pulse that has no queued expectation is reported, and so is any output that moves outside a done cycle.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam int ANG_W    = 16;
    localparam int OUT_W    = 17;
    localparam int ACC_W    = OUT_W + 1;
    localparam int MAX_ITER = 16;
    localparam int CNT_W    = $clog2(MAX_ITER + 1);
    localparam int IDX_W    = $clog2(MAX_ITER);

    localparam logic [ANG_W-1:0] HALF_TURN = ANG_W'(1) << (ANG_W - 1);
    localparam int               QUARTER   = 1 << (ANG_W - 2);

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [OUT_W-1:0] res_t;

    typedef struct packed {
        acc_t x;
        acc_t y;
        acc_t z;
    } vec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROT  = 2'd1,
        ST_FIX  = 2'd2
    } eng_state_t;

    // arctan(2^-k) scaled so that one turn is 2^16 codes
    function automatic logic [ANG_W-1:0] atan_code(input logic [IDX_W-1:0] k);
        case (k)
            4'd0:    return 16'h2000;
            4'd1:    return 16'h12E4;
            4'd2:    return 16'h09FB;
            4'd3:    return 16'h0511;
            4'd4:    return 16'h028B;
            4'd5:    return 16'h0145;
            4'd6:    return 16'h00A3;
            4'd7:    return 16'h0051;
            4'd8:    return 16'h0028;
            4'd9:    return 16'h0014;
            4'd10:   return 16'h000A;
            4'd11:   return 16'h0005;
            4'd12:   return 16'h0003;
            4'd13:   return 16'h0001;
            4'd14:   return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

    // Q16 product of 1/sqrt(1+4^-k) over the first n steps
    function automatic logic [ANG_W-1:0] gain_q16(input logic [CNT_W-1:0] n);
        case (n)
            5'd1:    return 16'hB505;
            5'd2:    return 16'hA1E9;
            5'd3:    return 16'h9D13;
            5'd4:    return 16'h9BDD;
            5'd5:    return 16'h9B8F;
            5'd6:    return 16'h9B7B;
            5'd7:    return 16'h9B77;
            default: return 16'h9B75;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] req);
        if (req == '0)
            return CNT_W'(1);
        else if (req > CNT_W'(MAX_ITER))
            return CNT_W'(MAX_ITER);
        else
            return req;
    endfunction

endpackage

// File: rtl/cordic_fold.sv
module cordic_fold
    import cordic_pkg::*;
(
    input  logic [ANG_W-1:0] phase,
    output acc_t             z_init,
    output logic             flip
);
    logic [ANG_W-1:0] adj;

    always_comb begin
        flip   = phase[ANG_W-1] ^ phase[ANG_W-2];
        adj    = flip ? (phase + HALF_TURN) : phase;
        z_init = ACC_W'($signed(adj));
    end

    always_comb begin
        AST_FOLD_RANGE: assert (z_init >= -acc_t'(QUARTER) && z_init < acc_t'(QUARTER)); // R2
    end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
    import cordic_pkg::*;
(
    input  vec_t             cur,
    input  logic [IDX_W-1:0] idx,
    output vec_t             nxt
);
    acc_t xv, yv, xs, ys, ang;
    logic ccw;

    always_comb begin
        xv  = cur.x;
        yv  = cur.y;
        xs  = xv >>> idx;
        ys  = yv >>> idx;
        ang = ACC_W'(atan_code(idx));
        ccw = ~cur.z[ACC_W-1];
        if (ccw) begin
            nxt.x = xv - ys;
            nxt.y = yv + xs;
            nxt.z = cur.z - ang;
        end else begin
            nxt.x = xv + ys;
            nxt.y = yv - xs;
            nxt.z = cur.z + ang;
        end
    end

endmodule

// File: rtl/cordic_signfix.sv
module cordic_signfix
    import cordic_pkg::*;
(
    input  acc_t val,
    input  logic flip,
    output res_t res
);
    localparam acc_t HI = acc_t'((1 << (OUT_W - 1)) - 1);
    localparam acc_t LO = -acc_t'(1 << (OUT_W - 1));

    acc_t s;

    always_comb begin
        s = flip ? -val : val;
        if (s > HI)
            res = HI[OUT_W-1:0];
        else if (s < LO)
            res = LO[OUT_W-1:0];
        else
            res = s[OUT_W-1:0];
    end

endmodule

// File: rtl/cordic_rot_engine.sv
module cordic_rot_engine
    import cordic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [15:0]             phase_i,
    input  logic [4:0]              iter_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic signed [16:0]      cos_o,
    output logic signed [16:0]      sin_o
);
    eng_state_t       state;
    vec_t             vec, vec_nx;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt_q, cnt_req;
    logic             flip_q, flip_w;
    acc_t             z_init;
    acc_t             fin [2];
    res_t             fixed [2];

    assign cnt_req = clamp_count(iter_i);
    assign busy_o  = (state != ST_IDLE);

    cordic_fold u_fold (
        .phase  (phase_i),
        .z_init (z_init),
        .flip   (flip_w)
    );

    cordic_stage u_stage (
        .cur (vec),
        .idx (idx),
        .nxt (vec_nx)
    );

    assign fin[0] = vec.x;
    assign fin[1] = vec.y;

    for (genvar g = 0; g < 2; g++) begin : g_fix
        cordic_signfix u_fix (
            .val  (fin[g]),
            .flip (flip_q),
            .res  (fixed[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            vec    <= '0;
            idx    <= '0;
            cnt_q  <= CNT_W'(1);
            flip_q <= 1'b0;
            done_o <= 1'b0;
            cos_o  <= '0;
            sin_o  <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        vec.x  <= acc_t'({2'b00, gain_q16(cnt_req)});
                        vec.y  <= '0;
                        vec.z  <= z_init;
                        flip_q <= flip_w;
                        cnt_q  <= cnt_req;
                        idx    <= '0;
                        state  <= ST_ROT;
                    end
                end
                ST_ROT: begin
                    vec <= vec_nx;
                    idx <= idx + 1'b1;
                    if ({1'b0, idx} == cnt_q - 1'b1)
                        state <= ST_FIX;
                end
                ST_FIX: begin
                    cos_o  <= fixed[0];
                    sin_o  <= fixed[1];
                    done_o <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o)); // R6
    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_IGNORE_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(cnt_q) && $stable(flip_q)); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(cos_o) && $stable(sin_o))); // R9
    AST_ITER_CAP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROT) |-> ({1'b0, idx} < cnt_q)); // R5

endmodule

// File: tb/sim_cordic_rot_engine.sv
`timescale 1ns/1ps
module sim_cordic_rot_engine;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start_i = 1'b0;
    logic [15:0]        phase_i = '0;
    logic [4:0]         iter_i = '0;
    logic               busy_o, done_o;
    logic signed [16:0] cos_o, sin_o;

    cordic_rot_engine u0 (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .phase_i (phase_i),
        .iter_i  (iter_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .cos_o   (cos_o),
        .sin_o   (sin_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int phase;
        int n;
        int issued;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    finished = 0;
    bit    prev_done = 0;
    int    last_cos = 0;
    int    last_sin = 0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
        end
    endtask

    function automatic int eff_count(input int r);
        if (r == 0) return 1;
        if (r > 16) return 16;
        return r;
    endfunction

    function automatic real absr(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    // driver: waits for idle, issues one request, pushes the expectation
    task automatic issue(input int ph, input int req);
        item_t it;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_i = 1'b1;
        phase_i = ph[15:0];
        iter_i  = req[4:0];
        it.phase = ph; it.n = eff_count(req); it.issued = cyc;
        q.push_back(it);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done_o) begin
                item_t it;
                check(!prev_done, "R7", "done longer than one cycle", 1.0, 0.0);
                check(!busy_o, "R6", "busy during done", 1.0, 0.0);
                if (q.size() == 0) begin
                    check(0, "R8", "done without accepted start", 1.0, 0.0);
                end else begin
                    real th, ec, es, tol;
                    int  sp;
                    it = q.pop_front();
                    check(cyc - it.issued == it.n + 2, "R5", "latency",
                          cyc - it.issued, it.n + 2);
                    sp = (it.phase >= 32768) ? it.phase - 65536 : it.phase;
                    th = 2.0 * 3.14159265358979 * sp / 65536.0;
                    if (it.n == 1) begin
                        ec = 46340.95; es = 46340.95; tol = 2.0;  // R4
                    end else begin
                        ec = 65536.0 * $cos(th); es = 65536.0 * $sin(th);
                        tol = 65536.0 / (2.0 ** (it.n - 1)) + 48.0;
                    end
                    check(absr($itor(cos_o) - ec) <= tol, "R1", "cos",
                          $itor(cos_o), ec);
                    check(absr($itor(sin_o) - es) <= tol, "R1", "sin",
                          $itor(sin_o), es);
                end
                last_cos = cos_o;
                last_sin = sin_o;
            end else begin
                if (cos_o != last_cos || sin_o != last_sin) begin
                    check(0, "R9", "output moved without done", cos_o, last_cos);
                end
            end
            prev_done = done_o;
        end
    end

    task automatic wait_drain();
        int guard = 0;
        while ((q.size() != 0 || busy_o) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(busy_o == 0, "R12", "busy after reset", busy_o, 0);
        check(done_o == 0, "R12", "done after reset", done_o, 0);
        check(cos_o == 0 && sin_o == 0, "R12", "outputs after reset", cos_o, 0);

        // R1 main function, no folding
        issue(16'h2000, 16);
        issue(16'h1234, 16);
        issue(16'hC000, 16);
        issue(16'hE000, 16);
        // R2 folded quadrants
        issue(16'h4000, 16);
        issue(16'h6000, 16);
        issue(16'hA000, 16);
        issue(16'h8000, 16);
        wait_drain();
        // R10 full scale must not wrap
        issue(16'h0000, 16);
        wait_drain();
        check(cos_o > 0, "R10", "cos at phase 0 positive", cos_o, 65535);
        issue(16'h4000, 16);
        wait_drain();
        check(sin_o > 0, "R10", "sin at 90 deg positive", sin_o, 65535);

        // R4 gain for one step, R3 clamp of zero and large counts
        issue(16'h0000, 1);
        issue(16'h0000, 0);   // R3 zero -> one
        issue(16'h3000, 31);  // R3 31 -> 16
        issue(16'h0800, 8);
        wait_drain();

        // R8 start while busy is ignored
        issue(16'h1000, 16);
        repeat (5) @(negedge clk);
        check(busy_o == 1, "R8", "busy mid-run", busy_o, 1);
        start_i = 1'b1; phase_i = 16'h7000; iter_i = 5'd3;
        @(negedge clk);
        start_i = 1'b0;
        wait_drain();
        check(q.size() == 0, "R8", "queue drained", q.size(), 0);

        // R11 start in the same cycle as done
        issue(16'h0400, 6);
        @(negedge clk);
        while (!done_o) @(negedge clk);
        begin
            item_t it;
            start_i = 1'b1; phase_i = 16'h5000; iter_i = 5'd12;
            it.phase = 16'h5000; it.n = 12; it.issued = cyc;
            q.push_back(it);
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o == 1, "R11", "start at done accepted", busy_o, 1);
        end
        wait_drain();
        check(q.size() == 0, "R11", "second result delivered", q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule